// File: doc/BRIEF.md
# Two-Clock Bus Request Decoder

This block watches a shared system bus and decodes each request phase, which always occupies two consecutive clocks and is opened by an active-low address strobe. The first clock carries the transaction kind on six command lines. The second clock reuses the same lines for a two-bit data-size code and a three-bit transfer length, and an address line carries a flag stating that ownership of the cache line is guaranteed. A single parity line covers the command lines and the strobe in each of the two clocks.

Every bus input is active-low. The decoder inverts the inputs, captures the fields of both clocks, and presents one complete request record with a one-cycle valid pulse. Parity failures are kept in two sticky flags, one for each clock of the phase, until software-facing logic pulses a clear. A strobe that arrives while a request is in its second clock is ignored and counted.

Top module: `reqphase_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero in the following cycle.
- R2: When `ads_n` is sampled low with no request in progress, `~req_n` at that edge becomes `rec_kind` of the record.
- R3: At the edge that follows an accepted strobe, `rec_dsz` takes `~req_n[4:3]` and `rec_len` takes `~req_n[2:0]`.
- R4: At that same second edge, `rec_own` takes `~own_n`.
- R5: `rec_valid` is high for exactly one cycle, the cycle after the second edge, and the record holds its value until the next second edge.
- R6: Parity is good when the XOR of the six inverted command bits, the inverted strobe and the inverted parity line is 0. A failure at the first edge sets `perr_first`.
- R7: A parity failure at the second edge sets `perr_second`.
- R8: Both parity flags stay set until `err_clr` is sampled high. A failure in the same cycle as the clear leaves its flag set.
- R9: A strobe sampled at the second edge does not start a request. It increments `proto_errs`, which saturates at its all-ones value.
- R10: A strobe in the clock directly after a second edge is accepted, so requests can run back to back every two clocks.
- R11: A record is delivered even when its parity failed. Parity is not checked in idle clocks, so a bad parity line with no request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| req_n | input | REQ_W (6) | Request command lines, active low |
| rp_n | input | 1 | Request parity line, active low |
| own_n | input | 1 | Address line 5, which carries the guaranteed-ownership flag in the second clock, active low |
| err_clr | input | 1 | Pulse that clears both parity flags |
| rec_valid | output | 1 | One-cycle pulse marking a new record |
| rec_kind | output | REQ_W (6) | Transaction kind from the first clock |
| rec_dsz | output | DSZ_W (2) | Data-size code from the second clock |
| rec_len | output | LEN_W (3) | Transfer length from the second clock |
| rec_own | output | 1 | Guaranteed-ownership flag |
| perr_first | output | 1 | Sticky parity error from a first clock |
| perr_second | output | 1 | Sticky parity error from a second clock |
| proto_errs | output | PCNT_W (4) | Saturating count of ignored strobes |

## Verification
The bench drives strobes during the second clock, which targets a design that restarts the phase: such a design would lose the original record's kind and produce valid pulses at the wrong cycles. It runs requests back to back to catch a design that needs an idle clock between them. It puts bad parity on each clock separately, pulses the clear in the same cycle as a new failure, and also drives bad parity in idle clocks, so that swapped flags, a clear that overrides a new failure, or parity checked when no request is open all show up. It drives more than fifteen stray strobes to show whether the counter wraps instead of saturating.

// File: rtl/reqphase_pkg.sv
// Package: shared widths and the decoded request record type.
// Assumes the six-line command bus with a 2-bit size field above a 3-bit
// length field in the second clock.
package reqphase_pkg;
    localparam int REQ_W = 6;
    localparam int DSZ_W = 2;
    localparam int LEN_W = 3;
    localparam int DSZ_LO = LEN_W;
    localparam int DSZ_HI = LEN_W + DSZ_W - 1;

    typedef struct packed {
        logic [REQ_W-1:0] kind;
        logic [DSZ_W-1:0] dsz;
        logic [LEN_W-1:0] len;
        logic             own;
    } req_rec_t;
endpackage

// File: rtl/reqphase_parity.sv
// Module: reqphase_parity
// Reduces a vector of active-high bus bits to an odd-parity indication.
// Assumes the caller includes the parity bit itself, so 0 means correct.
module reqphase_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    // Purpose: XOR-reduce every covered bit.
    always_comb begin
        odd_o = ^bits_i;
    end
endmodule

// File: rtl/reqphase_seq.sv
// Module: reqphase_seq
// Tracks which clock of the two-clock request phase is active and counts
// strobes that arrive in the second clock. Assumes the strobe is already
// inverted to active-high.
module reqphase_seq #(
    parameter int PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    output logic              start_o,
    output logic              second_o,
    output logic [PCNT_W-1:0] stray_cnt_o
);
    localparam logic [PCNT_W-1:0] CNT_MAX = {PCNT_W{1'b1}};

    logic              ph2_q;
    logic [PCNT_W-1:0] cnt_q;
    logic              stray;

    // Purpose: accept a strobe only outside the second clock.
    always_comb begin
        start_o  = strobe_i & ~ph2_q;
        stray    = strobe_i & ph2_q;
        second_o = ph2_q;
    end

    // Purpose: the second clock always follows an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ph2_q <= 1'b0;
        else        ph2_q <= start_o;
    end

    // Purpose: saturating count of strobes ignored in the second clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (stray && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign stray_cnt_o = cnt_q;

    // R9: a second clock is never followed by another second clock.
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_q |=> !ph2_q);
    // R9: the stray counter never goes down.
    p_cnt_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/reqphase_capture.sv
// Module: reqphase_capture
// Latches the first-clock kind, then builds the full record at the second
// clock and pulses valid for one cycle. Assumes active-high inputs and
// a start/second pair from reqphase_seq.
module reqphase_capture
    import reqphase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             second_i,
    input  logic [REQ_W-1:0] cmd_i,
    input  logic             own_i,
    output req_rec_t         rec_o,
    output logic             valid_o
);
    logic [REQ_W-1:0] kind_q;
    req_rec_t         rec_q;
    logic             valid_q;

    // Purpose: hold the transaction kind from the first clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       kind_q <= '0;
        else if (start_i) kind_q <= cmd_i;
    end

    // Purpose: assemble the record at the second clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (second_i) begin
            rec_q.kind <= kind_q;
            rec_q.dsz  <= cmd_i[DSZ_HI:DSZ_LO];
            rec_q.len  <= cmd_i[LEN_W-1:0];
            rec_q.own  <= own_i;
        end
    end

    // Purpose: one-cycle valid marking a fresh record.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= second_i;
    end

    assign rec_o   = rec_q;
    assign valid_o = valid_q;

    // R5: valid never lasts two cycles.
    p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R5: the record is stable between second clocks.
    p_rec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !second_i |=> $stable(rec_q));
endmodule

// File: rtl/reqphase_errflags.sv
// Module: reqphase_errflags
// Sticky parity-error flags for each of the two request clocks. A set
// in the same cycle as a clear wins. Assumes the fail inputs are already
// qualified by the active clock of the phase.
module reqphase_errflags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fail1_i,
    input  logic fail2_i,
    output logic err1_o,
    output logic err2_o
);
    logic err1_q;
    logic err2_q;

    // Purpose: first-clock flag, clear then set so that a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       err1_q <= 1'b0;
        else if (fail1_i) err1_q <= 1'b1;
        else if (clr_i)   err1_q <= 1'b0;
    end

    // Purpose: second-clock flag with the same priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       err2_q <= 1'b0;
        else if (fail2_i) err2_q <= 1'b1;
        else if (clr_i)   err2_q <= 1'b0;
    end

    assign err1_o = err1_q;
    assign err2_o = err2_q;

    // R8: a flag with no clear stays set.
    p_sticky1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err1_q && !clr_i |=> err1_q);
    p_sticky2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err2_q && !clr_i |=> err2_q);
    // R6, R7: a failure always shows in the following cycle.
    p_set1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail1_i |=> err1_q);
    p_set2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail2_i |=> err2_q);
endmodule

// File: rtl/reqphase_decoder.sv
// Module: reqphase_decoder (top)
// Decodes the two-clock request phase of an active-low bus into one record
// with a valid pulse, sticky parity flags and a stray-strobe count.
// Assumes all bus inputs are synchronous to clk.
module reqphase_decoder
    import reqphase_pkg::*;
#(
    parameter int PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              rp_n,
    input  logic              own_n,
    input  logic              err_clr,
    output logic              rec_valid,
    output logic [REQ_W-1:0]  rec_kind,
    output logic [DSZ_W-1:0]  rec_dsz,
    output logic [LEN_W-1:0]  rec_len,
    output logic              rec_own,
    output logic              perr_first,
    output logic              perr_second,
    output logic [PCNT_W-1:0] proto_errs
);
    localparam int PAR_W = REQ_W + 2;

    logic [REQ_W-1:0] cmd;
    logic             strobe;
    logic             par_bit;
    logic             own;
    logic             odd;
    logic             start;
    logic             second;
    req_rec_t         rec;

    // Purpose: bring the active-low bus to active-high.
    always_comb begin
        cmd     = ~req_n;
        strobe  = ~ads_n;
        par_bit = ~rp_n;
        own     = ~own_n;
    end

    reqphase_parity #(.W(PAR_W)) u_par (
        .bits_i ({cmd, strobe, par_bit}),
        .odd_o  (odd)
    );

    reqphase_seq #(.PCNT_W(PCNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .start_o     (start),
        .second_o    (second),
        .stray_cnt_o (proto_errs)
    );

    reqphase_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .second_i (second),
        .cmd_i    (cmd),
        .own_i    (own),
        .rec_o    (rec),
        .valid_o  (rec_valid)
    );

    reqphase_errflags u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (err_clr),
        .fail1_i (start & odd),
        .fail2_i (second & odd),
        .err1_o  (perr_first),
        .err2_o  (perr_second)
    );

    // Purpose: flatten the record onto plain output ports.
    always_comb begin
        rec_kind = rec.kind;
        rec_dsz  = rec.dsz;
        rec_len  = rec.len;
        rec_own  = rec.own;
    end

    // R5, R10: a second clock is always followed by a valid pulse.
    p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        second |=> rec_valid);
    // R10: an accepted strobe always leads into a second clock.
    p_start_to_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> second);
    // R11: without a request, parity flags do not rise.
    p_idle_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !second && !perr_first |=> !perr_first);
endmodule

// File: tb/reqphase_decoder_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks of each requirement.
module reqphase_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_n = 1'b1;
    logic [5:0] req_n = 6'h3F;
    logic       rp_n = 1'b1;
    logic       own_n = 1'b1;
    logic       err_clr = 1'b0;
    logic       rec_valid;
    logic [5:0] rec_kind;
    logic [1:0] rec_dsz;
    logic [2:0] rec_len;
    logic       rec_own;
    logic       perr_first;
    logic       perr_second;
    logic [3:0] proto_errs;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    reqphase_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .req_n(req_n), .rp_n(rp_n),
        .own_n(own_n), .err_clr(err_clr), .rec_valid(rec_valid),
        .rec_kind(rec_kind), .rec_dsz(rec_dsz), .rec_len(rec_len),
        .rec_own(rec_own), .perr_first(perr_first), .perr_second(perr_second),
        .proto_errs(proto_errs)
    );

    // reference model state
    int m_ph2 = 0, m_hold = 0, m_valid = 0, m_kind = 0, m_dsz = 0, m_len = 0;
    int m_own = 0, m_e1 = 0, m_e2 = 0, m_cnt = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int c, s, p, odd;
        c = ~req_n; c = c & 63;
        s = !ads_n; p = !rp_n;
        odd = ($countones(c[5:0]) + s + p) % 2;
        if (!rst_n) begin
            m_ph2 = 0; m_hold = 0; m_valid = 0; m_kind = 0; m_dsz = 0;
            m_len = 0; m_own = 0; m_e1 = 0; m_e2 = 0; m_cnt = 0;
        end else begin
            if (err_clr) begin m_e1 = 0; m_e2 = 0; end
            m_valid = 0;
            if (m_ph2 != 0) begin
                m_kind = m_hold; m_dsz = (c >> 3) & 3; m_len = c & 7;
                m_own = !own_n; m_valid = 1;
                if (odd != 0) m_e2 = 1;
                if (s != 0 && m_cnt < 15) m_cnt++;
                m_ph2 = 0;
            end else if (s != 0) begin
                m_hold = c; m_ph2 = 1;
                if (odd != 0) m_e1 = 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R5 valid", rec_valid, m_valid);
            chk("R2 kind", rec_kind, m_kind);
            chk("R3 dsz", rec_dsz, m_dsz);
            chk("R3 len", rec_len, m_len);
            chk("R4 own", rec_own, m_own);
            chk("R6 perr_first", perr_first, m_e1);
            chk("R7 perr_second", perr_second, m_e2);
            chk("R9 proto_errs", proto_errs, m_cnt);
        end
    end

    task automatic step(input bit s, input logic [5:0] cmd, input bit good,
                        input bit own, input bit clr);
        logic rp;
        @(negedge clk);
        rp = (^cmd) ^ s ^ !good;
        ads_n = !s; req_n = ~cmd; rp_n = !rp; own_n = !own; err_clr = clr;
    endtask

    task automatic idle();
        step(0, 6'h00, 1, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) idle();
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 valid", rec_valid, 0); chk("R1 kind", rec_kind, 0);
        chk("R1 perr", perr_first | perr_second, 0); chk("R1 cnt", proto_errs, 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // R2 R3 R4 R5: plain request with good parity
        step(1, 6'h2A, 1, 0, 0);
        step(1'b0, {1'b0, 2'b10, 3'b101}, 1, 1, 0);
        idle();
        chk("R5 valid pulse", rec_valid, 1);
        chk("R2 kind", rec_kind, 6'h2A);
        chk("R3 dsz", rec_dsz, 2);
        chk("R3 len", rec_len, 5);
        chk("R4 own", rec_own, 1);
        idle();
        chk("R5 single cycle", rec_valid, 0);
        chk("R5 record held", rec_kind, 6'h2A);

        // R6 R11: bad parity in first clock, record still delivered
        step(1, 6'h11, 0, 0, 0);
        step(0, 6'h07, 1, 0, 0);
        idle();
        chk("R11 valid despite parity", rec_valid, 1);
        chk("R6 perr_first", perr_first, 1);
        chk("R6 perr_second untouched", perr_second, 0);
        // R8: flag stays without clear, drops with it
        idle();
        chk("R8 sticky", perr_first, 1);
        step(0, 0, 1, 0, 1);
        idle();
        chk("R8 cleared", perr_first, 0);

        // R7: bad parity in second clock
        step(1, 6'h3C, 1, 0, 0);
        step(0, 6'h1B, 0, 1, 0);
        idle();
        chk("R7 perr_second", perr_second, 1);
        chk("R7 perr_first clean", perr_first, 0);
        chk("R3 len after bad parity", rec_len, 3);

        // R8: clear in the same cycle as a new first-clock failure
        step(1, 6'h05, 0, 0, 1);
        step(0, 6'h00, 1, 0, 0);
        idle();
        chk("R8 set wins over clear", perr_first, 1);
        chk("R8 clear applied to other flag", perr_second, 0);
        step(0, 0, 1, 0, 1);

        // R11: bad parity while idle has no effect
        repeat (4) step(0, 6'h15, 0, 1, 0);
        idle();
        chk("R11 idle parity ignored first", perr_first, 0);
        chk("R11 idle parity ignored second", perr_second, 0);
        chk("R11 no spurious valid", rec_valid, 0);

        // R10: back-to-back requests
        step(1, 6'h21, 1, 0, 0);
        step(0, 6'h0A, 1, 0, 0);
        step(1, 6'h12, 1, 0, 0);
        chk("R10 first valid", rec_valid, 1);
        chk("R10 first kind", rec_kind, 6'h21);
        step(0, 6'h16, 1, 1, 0);
        chk("R10 gap cycle", rec_valid, 0);
        idle();
        chk("R10 second valid", rec_valid, 1);
        chk("R10 second kind", rec_kind, 6'h12);
        chk("R10 second dsz", rec_dsz, 2);

        // R9: strobe during second clock is ignored and counted
        step(1, 6'h33, 1, 0, 0);
        step(1, 6'h09, 1, 0, 0);
        idle();
        chk("R9 kind kept", rec_kind, 6'h33);
        chk("R9 len from second clock", rec_len, 1);
        chk("R9 count", proto_errs, 1);
        idle();
        chk("R9 no restart", rec_valid, 0);
        // R9: saturation
        for (int i = 0; i < 17; i++) begin
            step(1, 6'h01, 1, 0, 0);
            step(1, 6'h02, 1, 0, 0);
        end
        idle(); idle();
        chk("R9 saturated", proto_errs, 15);

        repeat (3) idle();
        finish_run();
    end
endmodule